// File: doc/BRIEF.md
# Carry-Save Montgomery Modular Exponentiator

This block computes X^E mod M for an odd modulus M of N bits. The exponent is scanned from its most significant bit down. Each bit costs one Montgomery squaring. A Montgomery multiplication by the base follows the squaring whenever the bit is 1. Leading zero bits of the exponent cost no modular operation at all.

Every modular operation runs on one shared radix-2 Montgomery unit. That unit takes both of its operands in redundant sum/carry form and returns its result in the same form. Its adder path is a pair of carry-save rows and holds no carry chain. Inside the exponentiation loop no value is ever converted to binary. A single carry-propagate addition, followed by one conditional subtraction of M, produces the binary result at the very end.

The host supplies X, E, M and the constant 2^(2N+4) mod M, then pulses start. The result appears together with a one-cycle done pulse.

Top module: `mexp_engine`

## Requirements
- R1: For odd M, X < M and r2 = 2^(2N+4) mod M, the result after done equals X^E mod M.
- R2: An exponent of 0 yields 1 mod M, including the case X = 0.
- R3: A single-bit exponent 2^k yields X^(2^k) mod M. This is a pure chain of squarings.
- R4: An all-ones exponent yields the correct value. Every bit after the leading one needs a square followed by a multiply.
- R5: E = 1 returns X unchanged. This checks that entering and leaving the Montgomery domain form a round trip.
- R6: M = 1 yields 0 for any exponent.
- R7: The output is always below M. With X = M-1 and E = 1 the output is M-1.
- R8: done is high for exactly one cycle. result holds its value until the next completion.
- R9: start is ignored while a computation is in progress: the running job completes with its own operands and no extra done follows.
- R10: After reset, done is 0 and result is 0.
- R11: Each Montgomery operation runs exactly N+2 iterations. In every iteration the low bit of the redundant running sum is zero before the shift. Each result, as sum plus carry, stays below 2M.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse, sampled only when idle |
| base_i | input | N | Base X, must be below M |
| exp_i | input | EW | Exponent E |
| mod_i | input | N | Odd modulus M |
| r2_i | input | N | Constant 2^(2N+4) mod M |
| result_o | output | N | Binary result X^E mod M |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The bench targets the following corner cases:

- **E = 0:** a sequencer that squared through leading zeros, or that never left the "accumulator is one" state, would return the Montgomery image of 1 rather than 1.
- **M = 1 and X = M-1 with E = 1:** a missing or misplaced final conditional subtraction leaves the output at M or above.
- **All-ones and single-bit exponents:** one stresses back-to-back square/multiply pairs and the other long squaring chains. A wrong quotient bit, a lost carry in the serially consumed redundant multiplier, or a wrong iteration count corrupts both.
- **Start pulse while busy:** a restart during a computation would show up as a wrong result or a second done pulse.

// File: rtl/mexp_pkg.sv
package mexp_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WAIT,
        ST_STEP,
        ST_FIN
    } seq_state_e;

    typedef enum logic [1:0] {
        OP_ENTER,
        OP_SQR,
        OP_MUL,
        OP_EXIT
    } mm_op_e;

endpackage

// File: rtl/mexp_csa3.sv
module mexp_csa3 #(
    parameter int L = 8
) (
    input  logic [L-1:0] a_i,
    input  logic [L-1:0] b_i,
    input  logic [L-1:0] c_i,
    output logic [L-1:0] sum_o,
    output logic [L-1:0] carry_o
);

    for (genvar k = 0; k < L; k++) begin : g_bit
        assign sum_o[k] = a_i[k] ^ b_i[k] ^ c_i[k];
        if (k == 0) begin : g_lsb
            assign carry_o[k] = 1'b0;
        end else begin : g_up
            assign carry_o[k] = (a_i[k-1] & b_i[k-1]) | (a_i[k-1] & c_i[k-1])
                              | (b_i[k-1] & c_i[k-1]);
        end
    end

endmodule

// File: rtl/mexp_mont_core.sv
module mexp_mont_core #(
    parameter int N = 32
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         kick_i,
    input  logic [N+2:0] as_i,
    input  logic [N+2:0] ac_i,
    input  logic [N+2:0] bs_i,
    input  logic [N+2:0] bc_i,
    input  logic [N+2:0] mod_i,
    output logic [N+2:0] rs_o,
    output logic [N+2:0] rc_o,
    output logic         done_o
);

    localparam int L  = N + 3;
    localparam int CW = $clog2(N + 2) + 1;
    localparam logic [CW-1:0] LAST = CW'(N + 1);

    typedef struct packed {
        logic          busy;
        logic          done;
        logic [CW-1:0] cnt;
        logic [L-1:0]  as;
        logic [L-1:0]  ac;
        logic          cy;
        logic [L-1:0]  bs;
        logic [L-1:0]  bc;
        logic [L-1:0]  ps;
        logic [L-1:0]  pc;
        logic [L-1:0]  m;
        logic [L-1:0]  s;
        logic [L-1:0]  c;
    } core_t;

    core_t st_q, st_d;

    logic         a_bit, b_low, q_bit;
    logic [L-1:0] t1, t2;
    logic [L-1:0] pre_s, pre_c;
    logic [L-1:0] x1, y1, x2, y2;

    // B + M folded into one redundant pair when an operation starts
    mexp_csa3 #(.L(L)) u_pre (
        .a_i(bs_i), .b_i(bc_i), .c_i(mod_i), .sum_o(pre_s), .carry_o(pre_c)
    );

    mexp_csa3 #(.L(L)) u_lvl1 (
        .a_i(st_q.s), .b_i(st_q.c), .c_i(t1), .sum_o(x1), .carry_o(y1)
    );

    mexp_csa3 #(.L(L)) u_lvl2 (
        .a_i(x1), .b_i(y1), .c_i(t2), .sum_o(x2), .carry_o(y2)
    );

    always_comb begin
        a_bit = st_q.as[0] ^ st_q.ac[0] ^ st_q.cy;
        b_low = st_q.bs[0] ^ st_q.bc[0];
        q_bit = st_q.s[0] ^ st_q.c[0] ^ (a_bit & b_low);
        case ({a_bit, q_bit})
            2'b10:   begin t1 = st_q.bs; t2 = st_q.bc; end
            2'b01:   begin t1 = st_q.m;  t2 = '0;      end
            2'b11:   begin t1 = st_q.ps; t2 = st_q.pc; end
            default: begin t1 = '0;      t2 = '0;      end
        endcase
    end

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (kick_i) begin
            st_d.busy = 1'b1;
            st_d.cnt  = '0;
            st_d.as   = as_i;
            st_d.ac   = ac_i;
            st_d.cy   = 1'b0;
            st_d.bs   = bs_i;
            st_d.bc   = bc_i;
            st_d.ps   = pre_s;
            st_d.pc   = pre_c;
            st_d.m    = mod_i;
            st_d.s    = '0;
            st_d.c    = '0;
        end else if (st_q.busy) begin
            st_d.s   = {1'b0, x2[L-1:1]};
            st_d.c   = {1'b0, y2[L-1:1]};
            st_d.as  = {1'b0, st_q.as[L-1:1]};
            st_d.ac  = {1'b0, st_q.ac[L-1:1]};
            st_d.cy  = (st_q.as[0] & st_q.ac[0]) | (st_q.as[0] & st_q.cy)
                     | (st_q.ac[0] & st_q.cy);
            st_d.cnt = st_q.cnt + CW'(1);
            if (st_q.cnt == LAST) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign rs_o   = st_q.s;
    assign rc_o   = st_q.c;
    assign done_o = st_q.done;

    // R11
    low_bit_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.busy |-> !x2[0]);
    // R11
    iter_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.busy |-> (st_q.cnt <= LAST));
    // R11
    kick_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        kick_i |-> !st_q.busy);
    // R11
    result_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.done |-> (({1'b0, st_q.s} + {1'b0, st_q.c}) < {st_q.m, 1'b0}));

endmodule

// File: rtl/mexp_cs_resolve.sv
module mexp_cs_resolve #(
    parameter int N = 32
) (
    input  logic [N+2:0] s_i,
    input  logic [N+2:0] c_i,
    input  logic [N-1:0] mod_i,
    output logic [N+2:0] res_o
);

    localparam int L = N + 3;

    logic [L-1:0] full;
    logic [L-1:0] mext;

    always_comb begin
        full  = s_i + c_i;
        mext  = L'(mod_i);
        res_o = (full >= mext) ? (full - mext) : full;
    end

endmodule

// File: rtl/mexp_engine.sv
module mexp_engine import mexp_pkg::*; #(
    parameter int N  = 32,
    parameter int EW = 32
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          start_i,
    input  logic [N-1:0]  base_i,
    input  logic [EW-1:0] exp_i,
    input  logic [N-1:0]  mod_i,
    input  logic [N-1:0]  r2_i,
    output logic [N-1:0]  result_o,
    output logic          done_o
);

    localparam int L  = N + 3;
    localparam int IW = (EW > 1) ? $clog2(EW) : 1;

    typedef struct packed {
        seq_state_e    state;
        mm_op_e        op;
        logic          kick;
        logic          lead;
        logic [IW-1:0] idx;
        logic [EW-1:0] e;
        logic [N-1:0]  x;
        logic [N-1:0]  m;
        logic [N-1:0]  r2;
        logic [L-1:0]  accs;
        logic [L-1:0]  accc;
        logic [L-1:0]  xms;
        logic [L-1:0]  xmc;
        logic [N-1:0]  res;
        logic          done;
    } seq_t;

    seq_t st_q, st_d;

    logic [L-1:0] opa_s, opa_c, opb_s, opb_c;
    logic [L-1:0] mm_s, mm_c;
    logic         mm_done;
    logic [L-1:0] res_full;
    logic         adv;

    always_comb begin
        opa_s = st_q.accs;
        opa_c = st_q.accc;
        opb_s = st_q.accs;
        opb_c = st_q.accc;
        case (st_q.op)
            OP_ENTER: begin
                opa_s = L'(st_q.x);
                opa_c = '0;
                opb_s = L'(st_q.r2);
                opb_c = '0;
            end
            OP_MUL: begin
                opb_s = st_q.xms;
                opb_c = st_q.xmc;
            end
            OP_EXIT: begin
                opb_s = L'(1);
                opb_c = '0;
            end
            default: ;
        endcase
    end

    mexp_mont_core #(.N(N)) u_core (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .kick_i (st_q.kick),
        .as_i   (opa_s),
        .ac_i   (opa_c),
        .bs_i   (opb_s),
        .bc_i   (opb_c),
        .mod_i  (L'(st_q.m)),
        .rs_o   (mm_s),
        .rc_o   (mm_c),
        .done_o (mm_done)
    );

    mexp_cs_resolve #(.N(N)) u_resolve (
        .s_i   (st_q.accs),
        .c_i   (st_q.accc),
        .mod_i (st_q.m),
        .res_o (res_full)
    );

    always_comb begin
        st_d      = st_q;
        st_d.kick = 1'b0;
        st_d.done = 1'b0;
        adv       = 1'b0;
        case (st_q.state)
            ST_IDLE: begin
                if (start_i) begin
                    st_d.e     = exp_i;
                    st_d.x     = base_i;
                    st_d.m     = mod_i;
                    st_d.r2    = r2_i;
                    st_d.op    = OP_ENTER;
                    st_d.kick  = 1'b1;
                    st_d.lead  = 1'b1;
                    st_d.idx   = IW'(EW - 1);
                    st_d.state = ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (mm_done) begin
                    case (st_q.op)
                        OP_ENTER: begin
                            st_d.xms   = mm_s;
                            st_d.xmc   = mm_c;
                            st_d.state = ST_STEP;
                        end
                        OP_SQR: begin
                            st_d.accs = mm_s;
                            st_d.accc = mm_c;
                            if (st_q.e[st_q.idx]) begin
                                st_d.op   = OP_MUL;
                                st_d.kick = 1'b1;
                            end else begin
                                adv = 1'b1;
                            end
                        end
                        OP_MUL: begin
                            st_d.accs = mm_s;
                            st_d.accc = mm_c;
                            adv       = 1'b1;
                        end
                        default: begin
                            st_d.accs  = mm_s;
                            st_d.accc  = mm_c;
                            st_d.state = ST_FIN;
                        end
                    endcase
                end
            end
            ST_STEP: begin
                if (st_q.lead) begin
                    if (st_q.e[st_q.idx]) begin
                        st_d.accs = st_q.xms;
                        st_d.accc = st_q.xmc;
                        st_d.lead = 1'b0;
                    end
                    adv = 1'b1;
                end else begin
                    st_d.op    = OP_SQR;
                    st_d.kick  = 1'b1;
                    st_d.state = ST_WAIT;
                end
            end
            default: begin
                st_d.res   = res_full[N-1:0];
                st_d.done  = 1'b1;
                st_d.state = ST_IDLE;
            end
        endcase
        if (adv) begin
            if (st_q.idx == '0) begin
                if (st_d.lead) begin
                    st_d.accs  = L'(1);
                    st_d.accc  = '0;
                    st_d.state = ST_FIN;
                end else begin
                    st_d.op    = OP_EXIT;
                    st_d.kick  = 1'b1;
                    st_d.state = ST_WAIT;
                end
            end else begin
                st_d.idx   = st_q.idx - IW'(1);
                st_d.state = ST_STEP;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign result_o = st_q.res;
    assign done_o   = st_q.done;

    // R8
    done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);
    // R7
    result_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> (result_o < st_q.m));
    // R7
    fin_fits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.state == ST_FIN) |-> (res_full[L-1:N] == '0));
    // R9
    start_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.state != ST_IDLE) |=> ($stable(st_q.e) && $stable(st_q.m) && $stable(st_q.x)));

endmodule

// File: tb/mexp_engine_tb.sv
`timescale 1ns/1ps
module mexp_engine_tb_top;

    localparam int N  = 32;
    localparam int EW = 32;
    localparam int NV = 10;

    // columns: base, exponent, modulus, requirement number
    localparam logic [31:0] TX [NV] = '{32'd5, 32'd7, 32'd3, 32'd12345, 32'd77,
        32'd0, 32'hFFFF_FFFA, 32'd2, 32'd0, 32'h1234_5678};
    localparam logic [31:0] TE [NV] = '{32'd3, 32'd0, 32'h0001_0000, 32'hFFFF_FFFF,
        32'd1, 32'd5, 32'd1, 32'h8000_0000, 32'd0, 32'hDEAD_BEEF};
    localparam logic [31:0] TM [NV] = '{32'd23, 32'd101, 32'd1000003, 32'hFFFF_FFFB,
        32'h8000_0001, 32'd1, 32'hFFFF_FFFB, 32'hC000_0001, 32'd97, 32'hF123_4567};
    // R1, R2, R3, R4, R5, R6, R7, R3, R2, R1
    localparam int TR [NV] = '{1, 2, 3, 4, 5, 6, 7, 3, 2, 1};

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [N-1:0]  base = '0;
    logic [EW-1:0] expo = '0;
    logic [N-1:0]  modv = 32'd1;
    logic [N-1:0]  r2 = '0;
    logic [N-1:0]  result;
    logic          done;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    mexp_engine #(.N(N), .EW(EW)) dut_i (
        .clk_i    (clk),
        .rst_ni   (rst_n),
        .start_i  (start),
        .base_i   (base),
        .exp_i    (expo),
        .mod_i    (modv),
        .r2_i     (r2),
        .result_o (result),
        .done_o   (done)
    );

    function automatic longint unsigned ref_r2(input longint unsigned m);
        longint unsigned r = 1 % m;
        for (int i = 0; i < 2 * N + 4; i++) r = (r * 2) % m;
        return r;
    endfunction

    function automatic longint unsigned ref_pow(input longint unsigned x,
                                                input logic [31:0] e,
                                                input longint unsigned m);
        longint unsigned r = 1 % m;
        longint unsigned b = x % m;
        for (int i = 31; i >= 0; i--) begin
            r = (r * r) % m;
            if (e[i]) r = (r * b) % m;
        end
        return r;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input longint unsigned act, input longint unsigned exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic launch(input logic [31:0] x, input logic [31:0] e, input logic [31:0] m);
        @(negedge clk);
        base  = x;
        expo  = e;
        modv  = m;
        r2    = 32'(ref_r2(64'(m)));
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done(output bit ok);
        int cyc = 0;
        while (!done && cyc < 20000) begin
            @(negedge clk);
            cyc++;
        end
        ok = done;
    endtask

    task automatic run_one(input logic [31:0] x, input logic [31:0] e,
                           input logic [31:0] m, input string req);
        bit ok;
        longint unsigned exp;
        launch(x, e, m);
        wait_done(ok);
        exp = ref_pow(64'(x), e, 64'(m));
        check(ok, req, "completion", 64'(ok), 1);
        check(64'(result) == exp, req, "result", 64'(result), exp);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL R1 watchdog: actual=timeout expected=completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] held;
        logic [31:0] rm, rx, re;
        int extra;
        bit ok;
        longint unsigned expa;

        repeat (4) @(negedge clk);
        // R10 reset state
        check(done == 1'b0, "R10", "done in reset", 64'(done), 0);
        check(result == '0, "R10", "result in reset", 64'(result), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(done == 1'b0, "R10", "done after reset", 64'(done), 0);
        check(result == '0, "R10", "result after reset", 64'(result), 0);

        for (int i = 0; i < NV; i++) begin
            run_one(TX[i], TE[i], TM[i], $sformatf("R%0d", TR[i]));
            held = result;
            // R8 single-cycle done and held result
            repeat (3) begin
                @(negedge clk);
                check(done == 1'b0, "R8", "done pulse width", 64'(done), 0);
            end
            check(result == held, "R8", "result held", 64'(result), 64'(held));
        end

        // R1 and R11 on random odd moduli
        void'($urandom(32'h5eed));
        for (int i = 0; i < 8; i++) begin
            rm = $urandom | 32'd1;
            rx = $urandom % rm;
            re = $urandom;
            run_one(rx, re, rm, "R1/R11");
        end

        // R9 start while busy is ignored
        launch(32'd31337, 32'hFFFF_0000, 32'hFFFF_FFF1);
        expa = ref_pow(64'd31337, 32'hFFFF_0000, 64'hFFFF_FFF1);
        repeat (150) @(negedge clk);
        base  = 32'd9;
        expo  = 32'd3;
        modv  = 32'd101;
        r2    = 32'(ref_r2(64'd101));
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done(ok);
        check(ok, "R9", "completion", 64'(ok), 1);
        check(64'(result) == expa, "R9", "result of first job", 64'(result), expa);
        extra = 0;
        repeat (3000) begin
            @(negedge clk);
            if (done) extra++;
        end
        check(extra == 0, "R9", "extra done pulses", 64'(extra), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule